// File: doc/BRIEF.md
# Mixed-Size DRAM Bank Decoder

This block sits between a CPU with a 20-bit (1 MB) address space and four DRAM banks that are not all the same size. Two banks of 256 KB cover the bottom half of the space. Two banks of 64 KB sit directly above them. The block looks only at the four top address bits, A19 down to A16. The 256 KB banks are picked by A19:A18 alone, while the 64 KB banks need all four bits. For the selected bank it passes the shared row and column strobe requests through to that bank's own active-low RAS and CAS lines. It also drives an active-low "memory selected" line and a direction line for the RAM data bus transceiver.

A small cycle state machine frames each memory cycle and has two states. In `ST_IDLE` no cycle is open and every output is inactive. The transition `IDLE_TO_BUSY` is taken on a clock edge where `mem_req` is high. On that edge the upper address bits and the write flag are captured. In `ST_BUSY` the captured address drives the decode, so changes on the address bus cannot move the cycle to another bank. The transition `BUSY_TO_IDLE` is taken on the first edge where `mem_req` is low. After that edge all strobes, the select line and the direction line return to inactive. A new cycle can open only from `ST_IDLE`.

Top module: `dram_bank_decode`

## Requirements
- R1: With a cycle open and captured A19:A18 = 00 (addr_hi 0..3), bank 0 is the selected bank, whatever A17:A16 are.
- R2: With a cycle open and captured A19:A18 = 01 (addr_hi 4..7), bank 1 is the selected bank, whatever A17:A16 are.
- R3: With a cycle open and captured A19:A16 = 1000 (addr_hi 8), bank 2 is the selected bank.
- R4: With a cycle open and captured A19:A16 = 1001 (addr_hi 9), bank 3 is the selected bank.
- R5: Captured addr_hi values 10..15 select no bank: every ras_n and cas_n bit stays 1, mem_sel_n stays 1 and dir_to_cpu stays 0.
- R6: mem_sel_n is 0 exactly while the state is ST_BUSY and the captured address selects a bank; otherwise it is 1.
- R7: ras_n[b] is 0 exactly when ras_req is 1, the state is ST_BUSY and bank b is selected; cas_n[b] follows the same rule with cas_req. Bit b of each bus belongs to bank b.
- R8: dir_to_cpu is 1 (DRAM drives the CPU side) during a selected read cycle (captured cpu_wr = 0), and it is 0 during a selected write cycle and whenever mem_sel_n is 1.
- R9: addr_hi and cpu_wr are captured on the edge that opens the cycle; later changes while the state is ST_BUSY do not change which bank is strobed, mem_sel_n, or dir_to_cpu.
- R10: At most one bank has any strobe (RAS or CAS) at 0 in any cycle, for all 16 addr_hi codes.
- R11: After reset the state is ST_IDLE: all ras_n and cas_n bits are 1, mem_sel_n is 1, dir_to_cpu is 0, and ras_req and cas_req have no effect until a cycle opens.
- R12: The first edge with mem_req = 0 closes the cycle (BUSY_TO_IDLE), and all outputs are inactive from that edge on. A request still high on that edge does not reopen a cycle until the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | input | 1 | Memory cycle request; high opens a cycle, low closes it |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle, captured at cycle start |
| addr_hi | input | 4 | CPU address bits A19:A16 |
| ras_req | input | 1 | Shared row strobe request, active high |
| cas_req | input | 1 | Shared column strobe request, active high |
| ras_n | output | 4 | Per-bank row strobe, active low, bit b = bank b |
| cas_n | output | 4 | Per-bank column strobe, active low, bit b = bank b |
| mem_sel_n | output | 1 | Active low when any bank is selected in an open cycle |
| dir_to_cpu | output | 1 | Transceiver direction, 1 = DRAM to CPU |

## Verification
The decode is swept over all sixteen upper-address codes in read cycles. The swept values include every A17:A16 value under A19:A18 = 00 and 01, which tells the coarse 256 KB match apart from the fine 64 KB match and shows that codes 10..15 are left unmapped. The strobe requests are toggled on their own, both inside cycles and while idle, to separate per-bank gating from the cycle framing. Write cycles and an address and write-flag change in the middle of a cycle show whether the direction and the bank are taken from the captured values or from the live bus. Back-to-back requests check that the closing edge is honoured before a new cycle opens.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

    localparam int NUM_BANKS = 4;
    localparam int ADDR_HI_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } cyc_state_e;

    // Per-bank match: a bank hits when (addr & MASK) == VALUE.
    // Entry 0 is bank 0.
    localparam logic [NUM_BANKS-1:0][ADDR_HI_W-1:0] BANK_MASK = {
        4'b1111,   // bank 3: 64 KB
        4'b1111,   // bank 2: 64 KB
        4'b1100,   // bank 1: 256 KB
        4'b1100    // bank 0: 256 KB
    };

    localparam logic [NUM_BANKS-1:0][ADDR_HI_W-1:0] BANK_VALUE = {
        4'b1001,
        4'b1000,
        4'b0100,
        4'b0000
    };

endpackage

// File: rtl/dbd_cycle_fsm.sv
module dbd_cycle_fsm
    import dbd_pkg::*;
#(
    parameter int AW = ADDR_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_req,
    input  logic          cpu_wr,
    input  logic [AW-1:0] addr_in,
    output logic          busy,
    output logic [AW-1:0] addr_q,
    output logic          wr_q
);

    cyc_state_e state_q;
    cyc_state_e state_d;
    logic       open_cycle;

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        open_cycle = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mem_req) begin
                    state_d    = ST_BUSY;   // IDLE_TO_BUSY
                    open_cycle = 1'b1;
                end
            end
            ST_BUSY: begin
                if (!mem_req) begin
                    state_d = ST_IDLE;      // BUSY_TO_IDLE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and cycle capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (open_cycle) begin
                addr_q <= addr_in;
                wr_q   <= cpu_wr;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_BUSY);
    end

    // R9: captured address and flag hold for the whole cycle
    assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wr_q)));

    // R12: a low request while busy closes the cycle on the next edge
    assert_cycle_close_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> !busy);

endmodule

// File: rtl/dbd_addr_decode.sv
module dbd_addr_decode
    import dbd_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int AW = ADDR_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [NB-1:0] hit,
    output logic          any_hit
);

    for (genvar b = 0; b < NB; b++) begin : g_bank_match
        always_comb begin
            hit[b] = ((addr & BANK_MASK[b]) == BANK_VALUE[b]);
        end
    end

    always_comb begin
        any_hit = |hit;
    end

    // R10: the bank map never overlaps
    assert_map_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/dbd_strobe_gate.sv
module dbd_strobe_gate
    import dbd_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [NB-1:0] hit,
    input  logic          any_hit,
    input  logic          wr_q,
    input  logic          ras_req,
    input  logic          cas_req,
    output logic [NB-1:0] ras_n,
    output logic [NB-1:0] cas_n,
    output logic          mem_sel_n,
    output logic          dir_to_cpu
);

    for (genvar b = 0; b < NB; b++) begin : g_bank_strobe
        always_comb begin
            ras_n[b] = !(busy && hit[b] && ras_req);
            cas_n[b] = !(busy && hit[b] && cas_req);
        end
    end

    always_comb begin
        mem_sel_n  = !(busy && any_hit);
        dir_to_cpu = busy && any_hit && !wr_q;
    end

    // R7: no strobe without its request
    assert_ras_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_req |-> (&ras_n));
    assert_cas_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_req |-> (&cas_n));

endmodule

// File: rtl/dram_bank_decode.sv
module dram_bank_decode
    import dbd_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int AW = ADDR_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_req,
    input  logic          cpu_wr,
    input  logic [AW-1:0] addr_hi,
    input  logic          ras_req,
    input  logic          cas_req,
    output logic [NB-1:0] ras_n,
    output logic [NB-1:0] cas_n,
    output logic          mem_sel_n,
    output logic          dir_to_cpu
);

    logic          busy;
    logic [AW-1:0] addr_q;
    logic          wr_q;
    logic [NB-1:0] hit;
    logic          any_hit;

    dbd_cycle_fsm #(.AW(AW)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_req (mem_req),
        .cpu_wr  (cpu_wr),
        .addr_in (addr_hi),
        .busy    (busy),
        .addr_q  (addr_q),
        .wr_q    (wr_q)
    );

    dbd_addr_decode #(.NB(NB), .AW(AW)) i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_q),
        .hit     (hit),
        .any_hit (any_hit)
    );

    dbd_strobe_gate #(.NB(NB)) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .hit        (hit),
        .any_hit    (any_hit),
        .wr_q       (wr_q),
        .ras_req    (ras_req),
        .cas_req    (cas_req),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .mem_sel_n  (mem_sel_n),
        .dir_to_cpu (dir_to_cpu)
    );

    // R10: one bank's strobes at most
    assert_one_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(ras_n & cas_n)));

    // R5: no select means no strobes
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n |-> ((&ras_n) && (&cas_n)));

    // R8: direction only meaningful while selected
    assert_dir_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_to_cpu |-> !mem_sel_n);

    // R6: a strobe implies the global select
    assert_strobe_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (~(&ras_n) || ~(&cas_n)) |-> !mem_sel_n);

endmodule

// File: tb/test_dram_bank_decode.sv
module test_dram_bank_decode;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_req = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [3:0] addr_hi = 4'd0;
    logic       ras_req = 1'b0;
    logic       cas_req = 1'b0;
    logic [3:0] ras_n;
    logic [3:0] cas_n;
    logic       mem_sel_n;
    logic       dir_to_cpu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit         m_busy = 1'b0;
    int         m_addr = 0;
    bit         m_wr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_bank_decode i_dram_bank_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_req    (mem_req),
        .cpu_wr     (cpu_wr),
        .addr_hi    (addr_hi),
        .ras_req    (ras_req),
        .cas_req    (cas_req),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .mem_sel_n  (mem_sel_n),
        .dir_to_cpu (dir_to_cpu)
    );

    function automatic int ref_bank(int a);
        if (a < 4) return 0;
        if (a < 8) return 1;
        if (a == 8) return 2;
        if (a == 9) return 3;
        return -1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int bk;
        logic [3:0] e_ras;
        logic [3:0] e_cas;
        bit sel;
        bk = ref_bank(m_addr);
        sel = m_busy && (bk >= 0);
        e_ras = 4'hF;
        e_cas = 4'hF;
        if (sel && ras_req) e_ras[bk] = 1'b0;
        if (sel && cas_req) e_cas[bk] = 1'b0;
        check(tag, "ras_n", int'(ras_n), int'(e_ras));
        check(tag, "cas_n", int'(cas_n), int'(e_cas));
        check(tag, "mem_sel_n", int'(mem_sel_n), int'(!sel));
        check(tag, "dir_to_cpu", int'(dir_to_cpu), int'(sel && !m_wr));
        check("R10", "strobed banks", $countones(~(ras_n & cas_n)) <= 1 ? 1 : 0, 1);
    endtask

    // Drive on the falling edge, compare, then advance the model past the rising edge
    task automatic step(string tag, bit req, int a, bit wr, bit ras, bit cas);
        @(negedge clk);
        mem_req = req;
        addr_hi = a[3:0];
        cpu_wr  = wr;
        ras_req = ras;
        cas_req = cas;
        #1;
        compare(tag);
        @(posedge clk);
        if (!m_busy && req) begin
            m_busy = 1'b1;
            m_addr = a;
            m_wr   = wr;
        end else if (m_busy && !req) begin
            m_busy = 1'b0;
        end
    endtask

    // One full cycle: open, row strobe, row+column, release, close
    task automatic mem_cycle(string tag, int a, bit wr);
        step(tag, 1'b1, a, wr, 1'b0, 1'b0);
        step(tag, 1'b1, a, wr, 1'b1, 1'b0);
        step(tag, 1'b1, a, wr, 1'b1, 1'b1);
        step(tag, 1'b1, a, wr, 1'b0, 1'b1);
        step(tag, 1'b0, a, wr, 1'b0, 1'b0);
        step(tag, 1'b0, a, wr, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        // R11: reset state, strobe requests ignored while idle
        #2;
        ras_req = 1'b1;
        cas_req = 1'b1;
        #1;
        check("R11", "ras_n in reset", int'(ras_n), 4'hF);
        check("R11", "cas_n in reset", int'(cas_n), 4'hF);
        check("R11", "mem_sel_n in reset", int'(mem_sel_n), 1);
        check("R11", "dir_to_cpu in reset", int'(dir_to_cpu), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R11", 1'b0, 0, 1'b0, 1'b1, 1'b1);
        step("R11", 1'b0, 9, 1'b0, 1'b1, 1'b1);

        // R1..R5: sweep all sixteen codes with read cycles
        for (int a = 0; a < 16; a++) begin
            if (a < 4) tag = "R1";
            else if (a < 8) tag = "R2";
            else if (a == 8) tag = "R3";
            else if (a == 9) tag = "R4";
            else tag = "R5";
            mem_cycle(tag, a, 1'b0);
        end

        // R8: write cycles to each bank and an unmapped code
        mem_cycle("R8", 2, 1'b1);
        mem_cycle("R8", 7, 1'b1);
        mem_cycle("R8", 8, 1'b1);
        mem_cycle("R8", 9, 1'b1);
        mem_cycle("R8", 12, 1'b1);

        // R9: address and write flag move during an open cycle
        step("R9", 1'b1, 9, 1'b0, 1'b0, 1'b0);
        step("R9", 1'b1, 0, 1'b1, 1'b1, 1'b0);
        step("R9", 1'b1, 5, 1'b1, 1'b1, 1'b1);
        step("R9", 1'b1, 15, 1'b0, 1'b1, 1'b1);
        step("R9", 1'b0, 8, 1'b0, 1'b0, 1'b0);
        step("R9", 1'b0, 8, 1'b0, 1'b0, 1'b0);

        // R12: request stays high across a close; back-to-back cycles
        step("R12", 1'b1, 4, 1'b0, 1'b1, 1'b1);
        step("R12", 1'b1, 4, 1'b0, 1'b1, 1'b1);
        step("R12", 1'b0, 8, 1'b1, 1'b1, 1'b1);
        step("R12", 1'b1, 8, 1'b1, 1'b1, 1'b1);
        step("R12", 1'b1, 8, 1'b1, 1'b1, 1'b1);
        step("R12", 1'b0, 3, 1'b0, 1'b1, 1'b1);
        step("R12", 1'b0, 3, 1'b0, 1'b1, 1'b1);

        // R6, R7: strobe requests toggled on their own inside one cycle
        step("R7", 1'b1, 1, 1'b0, 1'b0, 1'b1);
        step("R7", 1'b1, 1, 1'b0, 1'b0, 1'b1);
        step("R7", 1'b1, 1, 1'b0, 1'b1, 1'b0);
        step("R6", 1'b1, 1, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 1, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 1, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule